// File: doc/BRIEF.md
# Periodic Tick Interrupt Timer

This block produces a periodic tick from the oscillator clock, for use as a steady time base for software. A 7-bit rate value sets the period. Its upper three bits give a power-of-two prescale exponent and its lower four bits give a linear multiplier. An exponent of zero turns the timer off. When a period ends, a sticky tick flag is set and the next period begins on the following cycle. An interrupt line follows the flag whenever the interrupt enable is set.

Software uses a small write port with three registers. The rate register is at address 0. The option register is at address 1: bit 0 is the interrupt enable, bit 1 halts the timer in wait mode, and bit 2 keeps it running in pseudo-stop. The flag register is at address 2, and writing a 1 to bit 0 clears the flag. Two mode inputs, `wait_mode` and `pstop_mode`, tell the timer that the system is in a low-power state. The option bits decide whether the timer runs or halts in each of those states.

The period is (m+1) × 2^(n+BASE_SHIFT) clock cycles, where n = rate[6:4] and m = rate[3:0]. BASE_SHIFT is 9 by default.

Top module: `rtick_timer`

## Requirements
- R1: After reset the rate is 0x00, the options are 0, and `tick_flag` and `irq` are 0. The timer is off and sets no flag until a rate is written.
- R2: With n = rate[6:4] nonzero and m = rate[3:0], `tick_flag` rises exactly (m+1)·2^(n+BASE_SHIFT) rising clock edges after the edge that accepts the rate write.
- R3: While n is 0, no time-out happens and the flag is never set, whatever the value of m.
- R4: Time-outs repeat every period with no idle cycle between periods. The second flag comes exactly two periods after the rate write.
- R5: Any write to the rate register restarts the period from zero, even if the value written is unchanged.
- R6: Writing address 2 with bit 0 = 1 clears the flag on that edge. Writing bit 0 = 0 leaves the flag as it is.
- R7: A time-out on the same edge as a clear write leaves the flag set.
- R8: `irq` is high exactly when the flag is set and option bit 0 (interrupt enable) is 1.
- R9: When option bit 1 is 1 and `wait_mode` is high, the timer halts and both counters are held at zero. The next flag comes one full period after the last edge in wait. When option bit 1 is 0, wait mode has no effect on the timer.
- R10: When `pstop_mode` is high and option bit 2 is 0, the timer freezes and keeps its progress, so the period is stretched by the number of halted edges. When option bit 2 is 1, pseudo-stop has no effect on the timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 rate, 1 options, 2 flag |
| wr_data | input | 7 | Write data |
| wait_mode | input | 1 | System is in wait mode |
| pstop_mode | input | 1 | System is in pseudo-stop mode |
| tick_flag | output | 1 | Sticky end-of-period flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle the relations that hold at all times. These are: no time-out while the exponent is zero, a flag that stays set without a clear, a time-out that wins against a clear, an interrupt only while the flag is set, a counter that returns to zero on a restart, and counters that hold still while halted in pseudo-stop. Only the bench scenarios can show the exact period length for each rate code, back-to-back periods, where the restart point falls after a rewrite, and how much a wait or pseudo-stop interval stretches or resets a period. All of these depend on counting edges against a formula.

// File: rtl/rtick_pkg.sv
package rtick_pkg;
    localparam int RATE_W = 7;
    localparam int EXP_W  = 3;
    localparam int MUL_W  = 4;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_RATE = 2'd0,
        ADDR_OPT  = 2'd1,
        ADDR_FLAG = 2'd2
    } rtick_addr_e;

    typedef struct packed {
        logic run_in_pstop;
        logic halt_in_wait;
        logic irq_en;
    } rtick_opt_t;
endpackage

// File: rtl/rtick_regs.sv
module rtick_regs
    import rtick_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [RATE_W-1:0]    wr_data,
    input  logic                 timeout,
    output logic [RATE_W-1:0]    rate,
    output rtick_opt_t           opt,
    output logic                 flag
);
    typedef struct packed {
        logic [RATE_W-1:0] rate;
        rtick_opt_t        opt;
        logic              flag;
    } regs_t;

    regs_t s_d, s_q;
    logic  clr_hit;

    assign clr_hit = wr_en && (wr_addr == ADDR_FLAG) && wr_data[0];

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            case (wr_addr)
                ADDR_RATE: s_d.rate = wr_data;
                ADDR_OPT: begin
                    s_d.opt.irq_en       = wr_data[0];
                    s_d.opt.halt_in_wait = wr_data[1];
                    s_d.opt.run_in_pstop = wr_data[2];
                end
                default: ;
            endcase
        end
        if (clr_hit) s_d.flag = 1'b0;
        if (timeout) s_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rate = s_q.rate;
    assign opt  = s_q.opt;
    assign flag = s_q.flag;

    // R6: flag is sticky unless a one is written to bit 0
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.flag && !clr_hit) |=> s_q.flag);

    // R6: clear write without a time-out drops the flag
    assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !timeout) |=> !s_q.flag);

    // R7: a time-out always leaves the flag set
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> s_q.flag);
endmodule

// File: rtl/rtick_prescaler.sv
module rtick_prescaler
    import rtick_pkg::*;
#(
    parameter int BASE_SHIFT = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EXP_W-1:0] exp_n,
    input  logic             run,
    input  logic             clear,
    output logic             stage_tick
);
    localparam int CW = BASE_SHIFT + (1 << EXP_W) - 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_t;

    pre_t          s_d, s_q;
    logic [CW-1:0] mask;

    always_comb begin
        mask       = ~({CW{1'b1}} << (32'(exp_n) + BASE_SHIFT));
        stage_tick = run && ((s_q.cnt & mask) == mask);
        s_d        = s_q;
        if (clear)           s_d.cnt = '0;
        else if (stage_tick) s_d.cnt = '0;
        else if (run)        s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R5: a restart puts the prescale counter back to zero
    assert_restart_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (s_q.cnt == '0));

    // R10: a halted, non-cleared prescaler holds its progress
    assert_halt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !run) |=> $stable(s_q.cnt));
endmodule

// File: rtl/rtick_divider.sv
module rtick_divider
    import rtick_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MUL_W-1:0] mul_m,
    input  logic             stage_tick,
    input  logic             clear,
    output logic             timeout
);
    typedef struct packed {
        logic [MUL_W-1:0] cnt;
    } div_t;

    div_t s_d, s_q;

    always_comb begin
        timeout = stage_tick && (s_q.cnt == mul_m);
        s_d     = s_q;
        if (clear)           s_d.cnt = '0;
        else if (timeout)    s_d.cnt = '0;
        else if (stage_tick) s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4: the next period starts from zero right after a time-out
    assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> (s_q.cnt == '0));

    // R5: a restart puts the divider back to zero
    assert_div_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (s_q.cnt == '0));
endmodule

// File: rtl/rtick_timer.sv
module rtick_timer
    import rtick_pkg::*;
#(
    parameter int BASE_SHIFT = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [6:0]        wr_data,
    input  logic              wait_mode,
    input  logic              pstop_mode,
    output logic              tick_flag,
    output logic              irq
);
    logic [RATE_W-1:0] rate;
    rtick_opt_t        opt;
    logic              flag;
    logic              timeout;
    logic              stage_tick;
    logic [EXP_W-1:0]  exp_n;
    logic [MUL_W-1:0]  mul_m;
    logic              rate_wr, off, wait_halt, pstop_halt, run, clear;

    assign exp_n      = rate[RATE_W-1:MUL_W];
    assign mul_m      = rate[MUL_W-1:0];
    assign rate_wr    = wr_en && (wr_addr == ADDR_RATE);
    assign off        = (exp_n == '0);
    assign wait_halt  = wait_mode && opt.halt_in_wait;
    assign pstop_halt = pstop_mode && !opt.run_in_pstop;
    assign clear      = rate_wr || wait_halt || off;
    assign run        = !off && !wait_halt && !pstop_halt;

    rtick_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .timeout (timeout),
        .rate    (rate),
        .opt     (opt),
        .flag    (flag)
    );

    rtick_prescaler #(.BASE_SHIFT(BASE_SHIFT)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .exp_n      (exp_n),
        .run        (run),
        .clear      (clear),
        .stage_tick (stage_tick)
    );

    rtick_divider u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .mul_m      (mul_m),
        .stage_tick (stage_tick),
        .clear      (clear),
        .timeout    (timeout)
    );

    assign tick_flag = flag;
    assign irq       = flag && opt.irq_en;

    // R3: exponent zero never yields a time-out
    assert_off_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_n == '0) |-> !timeout);

    // R8: no interrupt without a set flag
    assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> tick_flag);
endmodule

// File: tb/sim_rtick_timer.sv
`timescale 1ns/1ps
module sim_rtick_timer;
    localparam int BS = 2;
    localparam int NV = 6;
    // {rate, expected period} with period = (m+1) << (n+BS)
    localparam logic [23:0] VEC [NV] = '{
        {8'h10, 16'd8},
        {8'h23, 16'd64},
        {8'h3F, 16'd512},
        {8'h70, 16'd512},
        {8'h45, 16'd384},
        {8'h13, 16'd32}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [6:0] wr_data = '0;
    logic       wait_mode = 1'b0;
    logic       pstop_mode = 1'b0;
    logic       tick_flag, irq;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rtick_timer #(.BASE_SHIFT(BS)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wait_mode(wait_mode), .pstop_mode(pstop_mode),
        .tick_flag(tick_flag), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [6:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0; wr_data = '0; wr_addr = '0;
    endtask

    task automatic until_flag(input int cap, output int c);
        c = 0;
        while (c < cap) begin
            edges(1);
            c++;
            if (tick_flag) break;
        end
    endtask

    initial begin
        #600000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int c;
        edges(2);
        rst_n = 1'b1;
        edges(1);
        chk("R1 flag after reset", tick_flag, 0);
        chk("R1 irq after reset", irq, 0);
        edges(200);
        chk("R1 timer off after reset", tick_flag, 0);

        // Vector table: R2 period and R4 back-to-back second period
        for (int i = 0; i < NV; i++) begin
            logic [7:0]  r;
            logic [15:0] p;
            r = VEC[i][23:16];
            p = VEC[i][15:0];
            wr(2'd0, r[6:0]);
            until_flag(4000, c);
            chk($sformatf("R2 period rate=%0h", r), c, p);
            wr(2'd2, 7'd1);
            chk("R6 cleared", tick_flag, 0);
            c = c + 1;
            begin
                int c2;
                until_flag(4000, c2);
                chk($sformatf("R4 second period rate=%0h", r), c + c2, 2 * p);
            end
            wr(2'd0, 7'h00);
            wr(2'd2, 7'd1);
        end

        // R3: exponent zero
        wr(2'd0, 7'h0F);
        edges(400);
        chk("R3 off no flag", tick_flag, 0);

        // R8 irq gating
        wr(2'd1, 7'd1);
        wr(2'd0, 7'h10);
        until_flag(100, c);
        chk("R8 irq with enable", irq, 1);
        wr(2'd0, 7'h00);
        wr(2'd1, 7'd0);
        chk("R8 irq masked", irq, 0);
        chk("R8 flag still set", tick_flag, 1);

        // R6: writing 0 keeps flag, writing 1 clears
        wr(2'd2, 7'd0);
        chk("R6 zero write no effect", tick_flag, 1);
        wr(2'd2, 7'd1);
        chk("R6 one write clears", tick_flag, 0);

        // R5: rewrite restarts the period
        wr(2'd0, 7'h20);
        edges(10);
        wr(2'd0, 7'h20);
        edges(15);
        chk("R5 no flag before restart period", tick_flag, 0);
        edges(1);
        chk("R5 flag after restart period", tick_flag, 1);
        wr(2'd0, 7'h00);
        wr(2'd2, 7'd1);

        // R7: time-out coincides with clear
        wr(2'd0, 7'h10);
        until_flag(100, c);
        edges(7);
        wr(2'd2, 7'd1);
        chk("R7 set wins over clear", tick_flag, 1);
        wr(2'd0, 7'h00);
        wr(2'd2, 7'd1);

        // R9: wait with halt option resets dividers
        wr(2'd1, 7'd2);
        wr(2'd0, 7'h20);
        edges(10);
        wait_mode = 1'b1;
        edges(20);
        chk("R9 no flag in wait", tick_flag, 0);
        wait_mode = 1'b0;
        edges(15);
        chk("R9 no flag before full period", tick_flag, 0);
        edges(1);
        chk("R9 flag one period after wait", tick_flag, 1);
        wr(2'd0, 7'h00);
        wr(2'd2, 7'd1);
        // R9: without option, wait is ignored
        wr(2'd1, 7'd0);
        wait_mode = 1'b1;
        wr(2'd0, 7'h20);
        until_flag(100, c);
        chk("R9 wait ignored period", c, 16);
        wait_mode = 1'b0;
        wr(2'd0, 7'h00);
        wr(2'd2, 7'd1);

        // R10: pseudo-stop freezes progress
        wr(2'd0, 7'h20);
        edges(5);
        pstop_mode = 1'b1;
        edges(30);
        chk("R10 no flag in pstop", tick_flag, 0);
        pstop_mode = 1'b0;
        edges(10);
        chk("R10 no flag before stretched end", tick_flag, 0);
        edges(1);
        chk("R10 flag at stretched end", tick_flag, 1);
        wr(2'd0, 7'h00);
        wr(2'd2, 7'd1);
        // R10: run option keeps it going
        wr(2'd1, 7'd4);
        pstop_mode = 1'b1;
        wr(2'd0, 7'h20);
        until_flag(100, c);
        chk("R10 pstop run period", c, 16);
        pstop_mode = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule